// File: doc/BRIEF.md
# Security-Tagged Translation Buffer

This block is a small fully associative translation buffer for a processor that runs in a secure and a non-secure world. Each entry holds a virtual section tag, a physical page, a world tag and a resolved non-secure attribute. Entries are created from first-level translation descriptors or written directly into a lockdown slot. A lookup presents a virtual page number, the requester's world and an MMU-enable flag. One cycle later the block returns a hit flag, the physical page, the non-secure attribute and the bus protection bit derived from that attribute.

The stored attribute is not a plain copy of the descriptor bit. Any entry owned by the non-secure world is forced to non-secure, and so is any lockdown write tagged non-secure. As a result, only secure-world entries can produce secure accesses. When translation is off, the requester's world is passed through as the attribute. The block never checks the attribute's value and has no error output.

Top module: `sec_tlb`

## Requirements
- R1: After reset, `hit`, `ppn`, `ns_attr` and `prot_ns` are 0, and no lookup hits until an entry is written.
- R2: A fill descriptor with bits [1:0]=10 is a section, and its stored attribute is bit 19. With bit 18 clear, the entry matches only its own 12-bit VPN and returns descriptor bits [31:20] as `ppn`. With bit 18 set, it is a supersection: it matches any VPN with equal bits [11:4] and returns {descriptor[31:24], lookup VPN[3:0]}.
- R3: A fill descriptor with bits [1:0]=01 is a coarse-page pointer; its attribute comes from bit 3 and `ppn` is descriptor bits [31:20].
- R4: A fill descriptor with bits [1:0] equal to 00 or 11 creates no entry and does not move the replacement pointer.
- R5: A fill with `fill_world`=1 (non-secure) stores attribute 1, whatever the descriptor bit holds.
- R6: A lockdown write with `lock_world`=1 stores attribute 1, whatever `lock_ns` holds. A secure lockdown write stores `lock_ns` as given.
- R7: With `mmu_on`=1, a lookup hits only on a valid entry whose tag matches and whose world tag equals `lk_world`. Otherwise `hit`, `ppn` and `ns_attr` are 0.
- R8: With `mmu_on`=0, a lookup returns `hit`=1, `ppn`=`lk_vpn` and `ns_attr`=`lk_world`.
- R9: `prot_ns` always equals `ns_attr`, so a resolved attribute of 1 is presented on the bus as a non-secure access.
- R10: Results appear on the outputs one cycle after `lk_en` is sampled. A cycle with `lk_en`=0 drives all four outputs to 0 in the following cycle.
- R11: Fills replace entries in round-robin order starting at index 0. Entries written through the lockdown port are skipped as victims and are never evicted by fills.
- R12: `inval_all` clears every non-locked entry in one cycle; locked entries stay valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Create an entry from a first-level descriptor |
| fill_vpn | input | 12 | Virtual section number of the fill |
| fill_desc | input | 32 | First-level descriptor |
| fill_world | input | 1 | World owning the fill (1 = non-secure) |
| lock_en | input | 1 | Direct lockdown write |
| lock_idx | input | IW | Entry index targeted by the lockdown write |
| lock_vpn | input | 12 | Virtual tag of the lockdown write |
| lock_ppn | input | 12 | Physical page of the lockdown write |
| lock_ns | input | 1 | Requested attribute of the lockdown write |
| lock_world | input | 1 | World tag of the lockdown write |
| inval_all | input | 1 | Invalidate all non-locked entries |
| lk_en | input | 1 | Lookup request |
| lk_vpn | input | 12 | Lookup virtual page number |
| lk_world | input | 1 | Requester world (1 = non-secure) |
| mmu_on | input | 1 | Translation enabled |
| hit | output | 1 | Registered hit |
| ppn | output | 12 | Registered physical page |
| ns_attr | output | 1 | Registered resolved non-secure attribute |
| prot_ns | output | 1 | Bus protection bit (1 = non-secure) |

## Verification
The bench fills a section with attribute bit 19 clear from the non-secure world. A design that copied the descriptor bit would return attribute 0 there. It also uses a non-secure lockdown write that asks for attribute 0; a design that honoured that request would leak a secure access. Lookups of the same VPN from the opposite world must miss, which exposes any match that ignores the world tag. A supersection is probed with non-zero low VPN bits, which catches an unmasked compare or a wrong page splice. Replacement is driven past two locked slots and through an invalidate, so a pointer that evicted locked entries, or an invalidate that cleared them, loses a translation that must survive.

// File: rtl/sec_tlb.sv
module sec_tlb #(
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [11:0]   fill_vpn,
  input  logic [31:0]   fill_desc,
  input  logic          fill_world,
  input  logic          lock_en,
  input  logic [IW-1:0] lock_idx,
  input  logic [11:0]   lock_vpn,
  input  logic [11:0]   lock_ppn,
  input  logic          lock_ns,
  input  logic          lock_world,
  input  logic          inval_all,
  input  logic          lk_en,
  input  logic [11:0]   lk_vpn,
  input  logic          lk_world,
  input  logic          mmu_on,
  output logic          hit,
  output logic [11:0]   ppn,
  output logic          ns_attr,
  output logic          prot_ns
);

  logic [ENTRIES-1:0] vld, lck, sup, wld, nsa;
  logic [11:0] tag [ENTRIES];
  logic [11:0] pg  [ENTRIES];
  logic [IW-1:0] rr;

  wire is_sec  = fill_desc[1:0] == 2'b10;
  wire is_crs  = fill_desc[1:0] == 2'b01;
  wire fill_ok = fill_en & (is_sec | is_crs);
  wire f_ns    = fill_world | (is_sec ? fill_desc[19] : fill_desc[3]);
  wire f_sup   = is_sec & fill_desc[18];
  wire unused_desc = &{1'b0, fill_desc[17:4], fill_desc[2]};

  logic          vic_ok;
  logic [IW-1:0] vic;
  always_comb begin
    vic_ok = 1'b0;
    vic    = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = (int'(rr) + k) % ENTRIES;
      if (!vic_ok && !lck[j]) begin
        vic_ok = 1'b1;
        vic    = IW'(j);
      end
    end
  end

  logic        m_hit, m_ns;
  logic [11:0] m_pg;
  always_comb begin
    m_hit = 1'b0;
    m_ns  = 1'b0;
    m_pg  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!m_hit && vld[i] && wld[i] == lk_world &&
          (sup[i] ? tag[i][11:4] == lk_vpn[11:4] : tag[i] == lk_vpn)) begin
        m_hit = 1'b1;
        m_ns  = nsa[i];
        m_pg  = sup[i] ? {pg[i][11:4], lk_vpn[3:0]} : pg[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; lck <= '0; sup <= '0; wld <= '0; nsa <= '0;
      rr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        pg[i]  <= '0;
      end
    end else begin
      if (inval_all) vld <= vld & lck;
      if (fill_ok && vic_ok) begin
        vld[vic] <= 1'b1;
        sup[vic] <= f_sup;
        wld[vic] <= fill_world;
        nsa[vic] <= f_ns;
        tag[vic] <= fill_vpn;
        pg[vic]  <= fill_desc[31:20];
        rr       <= (int'(vic) == ENTRIES - 1) ? '0 : vic + 1'b1;
      end
      if (lock_en) begin
        vld[lock_idx] <= 1'b1;
        lck[lock_idx] <= 1'b1;
        sup[lock_idx] <= 1'b0;
        wld[lock_idx] <= lock_world;
        nsa[lock_idx] <= lock_world | lock_ns;
        tag[lock_idx] <= lock_vpn;
        pg[lock_idx]  <= lock_ppn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lk_en) begin
      hit <= 1'b0; ppn <= '0; ns_attr <= 1'b0;
    end else if (!mmu_on) begin
      hit <= 1'b1; ppn <= lk_vpn; ns_attr <= lk_world;
    end else begin
      hit <= m_hit; ppn <= m_pg; ns_attr <= m_ns;
    end
  end

  assign prot_ns = ns_attr;

endmodule

// File: rtl/sec_tlb_chk.sv
module sec_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_en,
  input logic        lk_world,
  input logic        mmu_on,
  input logic [11:0] lk_vpn,
  input logic        hit,
  input logic [11:0] ppn,
  input logic        ns_attr
);

  // R5
  ns_world_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_world) |=> (!hit || ns_attr));

  // R8
  mmu_off_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !mmu_on) |=> (hit && ns_attr == $past(lk_world) && ppn == $past(lk_vpn)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!hit && ppn == 12'h000 && !ns_attr));

  // R10
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(lk_en));

endmodule

bind sec_tlb sec_tlb_chk u_chk (.*);

// File: tb/test_sec_tlb.sv
module test_sec_tlb;
  localparam int ENTRIES = 4;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic fill_en = 0, fill_world = 0, lock_en = 0, lock_ns = 0, lock_world = 0;
  logic inval_all = 0, lk_en = 0, lk_world = 0, mmu_on = 1;
  logic [11:0] fill_vpn = '0, lock_vpn = '0, lock_ppn = '0, lk_vpn = '0;
  logic [31:0] fill_desc = '0;
  logic [IW-1:0] lock_idx = '0;
  logic hit, ns_attr, prot_ns;
  logic [11:0] ppn;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec_tlb #(.ENTRIES(ENTRIES)) i_sec_tlb (.*);

  // {req, mmu_on, world, vpn, exp_hit, exp_ppn, exp_ns}
  localparam logic [31:0] TV [10] = '{
    {4'd2, 1'b1, 1'b0, 12'h100, 1'b1, 12'hA01, 1'b0}, // R2 section, bit19 clear
    {4'd2, 1'b1, 1'b0, 12'h200, 1'b1, 12'hB02, 1'b1}, // R2 section, bit19 set
    {4'd5, 1'b1, 1'b1, 12'h300, 1'b1, 12'hC03, 1'b1}, // R5 forced
    {4'd7, 1'b1, 1'b0, 12'h300, 1'b0, 12'h000, 1'b0}, // R7 world mismatch
    {4'd7, 1'b1, 1'b1, 12'h100, 1'b0, 12'h000, 1'b0}, // R7 world mismatch
    {4'd3, 1'b1, 1'b0, 12'h400, 1'b1, 12'hD04, 1'b1}, // R3 coarse bit3
    {4'd4, 1'b1, 1'b0, 12'h500, 1'b0, 12'h000, 1'b0}, // R4 rejected
    {4'd8, 1'b0, 1'b0, 12'h123, 1'b1, 12'h123, 1'b0}, // R8 secure flat
    {4'd8, 1'b0, 1'b1, 12'h456, 1'b1, 12'h456, 1'b1}, // R8 non-secure flat
    {4'd7, 1'b1, 1'b0, 12'h101, 1'b0, 12'h000, 1'b0}  // R7 tag mismatch
  };

  // every comparison also covers R9 (prot_ns tracks ns_attr)
  task automatic chk_out(input int rq, input logic eh, input logic [11:0] ep, input logic en);
    checks++;
    if (hit !== eh || ppn !== ep || ns_attr !== en || prot_ns !== en) begin
      fails++;
      $display("FAIL R%0d hit/ppn/ns/prot = %b/%h/%b/%b expected %b/%h/%b/%b",
               rq, hit, ppn, ns_attr, prot_ns, eh, ep, en, en);
    end
  endtask

  task automatic do_fill(input logic w, input logic [11:0] v, input logic [31:0] d);
    @(negedge clk);
    fill_en = 1; fill_world = w; fill_vpn = v; fill_desc = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_lock(input logic [IW-1:0] ix, input logic w, input logic n,
                         input logic [11:0] v, input logic [11:0] p);
    @(negedge clk);
    lock_en = 1; lock_idx = ix; lock_world = w; lock_ns = n; lock_vpn = v; lock_ppn = p;
    @(negedge clk);
    lock_en = 0;
  endtask

  task automatic look(input logic m, input logic w, input logic [11:0] v);
    @(negedge clk);
    lk_en = 1; mmu_on = m; lk_world = w; lk_vpn = v;
    @(negedge clk);
    lk_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_out(1, 0, 12'h000, 0);            // R1 reset outputs
    rst_n = 1;
    look(1, 0, 12'h100);
    chk_out(1, 0, 12'h000, 0);            // R1 empty after reset

    do_fill(0, 12'h100, 32'hA010_0002);
    do_fill(0, 12'h200, 32'hB028_0002);
    do_fill(1, 12'h300, 32'hC030_0002);
    do_fill(0, 12'h400, 32'hD040_0009);
    do_fill(0, 12'h500, 32'hE050_0003);   // R4 rejected encoding

    for (int i = 0; i < 10; i++) begin
      look(TV[i][27], TV[i][26], TV[i][25:14]);
      chk_out(int'(TV[i][31:28]), TV[i][13], TV[i][12:1], TV[i][0]);
    end

    // R10: idle cycle clears outputs
    look(1, 0, 12'h100);
    @(negedge clk);
    chk_out(10, 0, 12'h000, 0);           // R10

    // R6 lockdown writes
    do_lock(2'd1, 1, 0, 12'h600, 12'h777);
    look(1, 1, 12'h600);
    chk_out(6, 1, 12'h777, 1);            // R6 forced
    do_lock(2'd2, 0, 0, 12'h700, 12'h888);
    look(1, 0, 12'h700);
    chk_out(6, 1, 12'h888, 0);            // R6 secure kept

    // R2 supersection into entry 0
    do_fill(0, 12'h810, 32'h9A04_0002);
    look(1, 0, 12'h81C);
    chk_out(2, 1, 12'h9AC, 0);            // R2 supersection splice

    // R11: next fill skips locked 1,2 and lands in 3
    do_fill(0, 12'h900, 32'h1110_0002);
    look(1, 0, 12'h400);
    chk_out(11, 0, 12'h000, 0);           // R11 entry 3 replaced
    look(1, 1, 12'h600);
    chk_out(11, 1, 12'h777, 1);           // R11 locked survives
    do_fill(0, 12'hA00, 32'h2220_0002);
    look(1, 0, 12'h81C);
    chk_out(11, 0, 12'h000, 0);           // R11 wrapped to entry 0
    look(1, 0, 12'h900);
    chk_out(11, 1, 12'h111, 0);           // R11 entry 3 untouched

    // R12 invalidate
    @(negedge clk); inval_all = 1;
    @(negedge clk); inval_all = 0;
    look(1, 0, 12'h900);
    chk_out(12, 0, 12'h000, 0);           // R12
    look(1, 0, 12'hA00);
    chk_out(12, 0, 12'h000, 0);           // R12
    look(1, 1, 12'h600);
    chk_out(12, 1, 12'h777, 1);           // R12 locked kept
    look(1, 0, 12'h700);
    chk_out(12, 1, 12'h888, 0);           // R12 locked kept

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule